// File: doc/BRIEF.md
# Wear-Levelled Append-Only Value Store

This block keeps one 16-bit value across many updates in a single erasable page of halfword slots. The page is modelled as an on-chip array whose erased cells read all ones. A write never rewrites a used cell. It appends the new value to the lowest erased slot, so wear spreads evenly over the page. Only when no erased slot is left is the whole page erased, after which the value lands in slot 0.

The block keeps no pointer and no copy of the value. The write position is found by scanning upward from slot 0 for the first erased cell. The current value is found by scanning downward from the top slot for the first cell that is not erased. The scans examine one slot per clock. Every erase is followed by a full check that every cell reads all ones, and every program is followed by a read-back compare.

A client raises one of four one-cycle requests: write, read, init or wipe. It then waits for `busy` to fall and samples `status`, plus `rd_value` after a read. The `stuck_bits` input models worn cells. Any bit set there is forced to zero in every cell that is erased or programmed, so erase and verify failures can be provoked.

Top module: `wl_value_store`

## Requirements
- R1: After reset, `busy` is 0, `status` is 0 (OK) and `rd_value` is 0xFFFF.
- R2: A request seen while idle raises `busy` on the next cycle. Requests seen while busy have no effect. When several requests arrive together, wipe wins over init, init over write, and write over read. `status` and `rd_value` change only on the cycle on which `busy` falls.
- R3: A write programs the lowest slot, counting from slot 0, that reads 0xFFFF. When that is slot k, `busy` stays high for k+3 cycles and ends with status 0. Writing 0xFFFF leaves the slot erased.
- R4: A write to a page with no erased slot erases the page, verifies it and then programs slot 0. `busy` stays high for 3*SLOTS+2 cycles, and a following read returns the new value.
- R5: Programming only clears bits: the cell becomes old AND data AND NOT `stuck_bits`. If the read-back differs from the data, the write ends with status 3 (verify error), with the same busy length as a good write.
- R6: A read scans from slot SLOTS-1 down and returns the first cell that is not 0xFFFF, with busy lasting SLOTS-j cycles for slot j and status 0. If every slot is erased, it returns 0xFFFF after SLOTS cycles.
- R7: An erase writes every slot and then checks that all read 0xFFFF. The first mismatch ends the operation with status 2 (erase error) one cycle into the check. A clean wipe takes 2*SLOTS busy cycles and ends with status 0.
- R8: Init erases the page (3*SLOTS busy cycles, status 0) only if every slot already reads 0xFFFF. If slot j is the lowest slot holding data, init leaves the page untouched and ends after j+1 cycles with status 0.
- R9: Status code 1 (write error) is reserved and never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Start a write of `wr_data` |
| wr_data | input | DATA_W | Value to append |
| rd_req | input | 1 | Start a read of the latest value |
| init_req | input | 1 | Erase the page only if it is entirely blank |
| wipe_req | input | 1 | Erase the page unconditionally |
| stuck_bits | input | DATA_W | Bits forced to zero in every cell written (worn-cell model) |
| busy | output | 1 | High while an operation runs |
| rd_value | output | DATA_W | Result of the last read |
| status | output | 2 | Result of the last operation: 0 OK, 1 write error, 2 erase error, 3 verify error |

## Verification
The bound checker watches several properties on every cycle: the reset state, that a request taken while idle raises busy, that status and value move only as busy falls, that status 1 never appears, and that no operation outlasts the worst case of a full-page write. Other behaviours show only in the bench's scenarios, where a reference page model predicts status, value and exact busy length. These include the slot chosen by each scan, the wrap after a full page, request priority, requests ignored while busy, init leaving a page with data untouched, and failures provoked through stuck bits.

// File: rtl/store_pkg.sv
package store_pkg;
  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_WRITE_ERR  = 2'd1,
    ST_ERASE_ERR  = 2'd2,
    ST_VERIFY_ERR = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSCAN,
    PH_PROG,
    PH_PVER,
    PH_ERASE,
    PH_EVER,
    PH_RSCAN,
    PH_ICHK
  } phase_e;
endpackage

// File: rtl/wl_slot_array.sv
module wl_slot_array #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic              erase_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] stuck,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [SLOTS];

  // Page powers up blank.
  initial begin
    for (int i = 0; i < SLOTS; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (erase_en)
      cells[addr] <= ~stuck;
    else if (prog_en)
      cells[addr] <= cells[addr] & prog_data & ~stuck;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/wl_store_seq.sv
module wl_store_seq
  import store_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              init_req,
  input  logic              wipe_req,
  input  logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  addr,
  output logic              prog_en,
  output logic              erase_en,
  output logic [DATA_W-1:0] prog_data,
  output logic              busy,
  output logic [1:0]        status,
  output logic [DATA_W-1:0] value
);
  localparam logic [IDX_W-1:0]  LAST   = IDX_W'(SLOTS - 1);
  localparam logic [DATA_W-1:0] ERASED = '1;

  phase_e            phase;
  logic [IDX_W-1:0]  idx, tgt;
  logic [DATA_W-1:0] data_q, value_q;
  logic              pend_wr;
  status_e           status_q;
  logic              blank;

  assign blank     = (rdata == ERASED);
  assign addr      = (phase == PH_PROG || phase == PH_PVER) ? tgt : idx;
  assign prog_en   = (phase == PH_PROG);
  assign erase_en  = (phase == PH_ERASE);
  assign prog_data = data_q;
  assign busy      = (phase != PH_IDLE);
  assign status    = status_q;
  assign value     = value_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      tgt      <= '0;
      data_q   <= '0;
      pend_wr  <= 1'b0;
      status_q <= ST_OK;
      value_q  <= ERASED;
    end else begin
      case (phase)
        PH_IDLE: begin
          pend_wr <= 1'b0;
          if (wipe_req) begin
            idx   <= '0;
            phase <= PH_ERASE;
          end else if (init_req) begin
            idx   <= '0;
            phase <= PH_ICHK;
          end else if (wr_req) begin
            idx    <= '0;
            data_q <= wr_data;
            phase  <= PH_WSCAN;
          end else if (rd_req) begin
            idx   <= LAST;
            phase <= PH_RSCAN;
          end
        end
        PH_WSCAN: begin
          if (blank) begin
            tgt   <= idx;
            phase <= PH_PROG;
          end else if (idx == LAST) begin
            idx     <= '0;
            pend_wr <= 1'b1;
            phase   <= PH_ERASE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_PROG: phase <= PH_PVER;
        PH_PVER: begin
          status_q <= (rdata == data_q) ? ST_OK : ST_VERIFY_ERR;
          phase    <= PH_IDLE;
        end
        PH_ERASE: begin
          idx <= (idx == LAST) ? '0 : idx + 1'b1;
          if (idx == LAST) phase <= PH_EVER;
        end
        PH_EVER: begin
          if (!blank) begin
            status_q <= ST_ERASE_ERR;
            phase    <= PH_IDLE;
          end else if (idx == LAST) begin
            if (pend_wr) begin
              tgt   <= '0;
              phase <= PH_PROG;
            end else begin
              status_q <= ST_OK;
              phase    <= PH_IDLE;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_RSCAN: begin
          if (!blank || idx == '0) begin
            value_q  <= rdata;
            status_q <= ST_OK;
            phase    <= PH_IDLE;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        PH_ICHK: begin
          if (!blank) begin
            status_q <= ST_OK;
            phase    <= PH_IDLE;
          end else if (idx == LAST) begin
            idx   <= '0;
            phase <= PH_ERASE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wl_value_store.sv
module wl_value_store #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              init_req,
  input  logic              wipe_req,
  input  logic [DATA_W-1:0] stuck_bits,
  output logic              busy,
  output logic [DATA_W-1:0] rd_value,
  output logic [1:0]        status
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [IDX_W-1:0]  arr_addr;
  logic              arr_prog, arr_erase;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  wl_slot_array #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_array (
    .clk       (clk),
    .prog_en   (arr_prog),
    .erase_en  (arr_erase),
    .addr      (arr_addr),
    .prog_data (arr_wdata),
    .stuck     (stuck_bits),
    .rdata     (arr_rdata)
  );

  wl_store_seq #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .init_req  (init_req),
    .wipe_req  (wipe_req),
    .rdata     (arr_rdata),
    .addr      (arr_addr),
    .prog_en   (arr_prog),
    .erase_en  (arr_erase),
    .prog_data (arr_wdata),
    .busy      (busy),
    .status    (status),
    .value     (rd_value)
  );
endmodule

// File: rtl/wl_value_store_chk.sv
module wl_value_store_chk #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic              rd_req,
  input logic              init_req,
  input logic              wipe_req,
  input logic              busy,
  input logic [DATA_W-1:0] rd_value,
  input logic [1:0]        status
);
  localparam int MAX_RUN = 3 * SLOTS + 2;
  logic [$clog2(MAX_RUN + 2):0] run;

  always_ff @(posedge clk) begin
    if (rst || !busy) run <= '0;
    else if (run <= ($bits(run))'(MAX_RUN)) run <= run + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && status == 2'd0 && rd_value == {DATA_W{1'b1}}));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && (wr_req || rd_req || init_req || wipe_req)) |=> busy);

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (busy || !$past(busy))) |-> ($stable(status) && $stable(rd_value)));

  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < ($bits(run))'(MAX_RUN)));

  // R9
  no_write_err_chk: assert property (@(posedge clk) disable iff (rst)
    status != 2'd1);
endmodule

bind wl_value_store wl_value_store_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_req   (wr_req),
  .rd_req   (rd_req),
  .init_req (init_req),
  .wipe_req (wipe_req),
  .busy     (busy),
  .rd_value (rd_value),
  .status   (status)
);

// File: tb/wl_value_store_tb.sv
module wl_value_store_tb;
  localparam int DW = 16;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0, rd_req = 1'b0, init_req = 1'b0, wipe_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] stuck = '0;
  logic          busy;
  logic [DW-1:0] rd_value;
  logic [1:0]    status;

  always #2 clk = ~clk;

  wl_value_store #(.DATA_W(DW), .SLOTS(NS)) u_dut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .init_req(init_req), .wipe_req(wipe_req), .stuck_bits(stuck),
    .busy(busy), .rd_value(rd_value), .status(status)
  );

  typedef struct {
    logic [1:0]    st;
    logic [DW-1:0] val;
    int            lat;
    string         tag;
  } exp_t;

  exp_t          q[$];
  logic [DW-1:0] mdl [NS];
  logic [DW-1:0] cur_val = '1;
  int            checks = 0, errors = 0;
  bit            done = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic m_erase(inout exp_t e);
    for (int i = 0; i < NS; i++) mdl[i] = ~stuck;
    if (~stuck != {DW{1'b1}}) begin
      e.st = 2'd2; e.lat += NS + 1;
    end else e.lat += 2 * NS;
  endtask

  task automatic m_prog(inout exp_t e, input int k, input logic [DW-1:0] d);
    mdl[k] = mdl[k] & d & ~stuck;
    e.lat += 2;
    e.st = (mdl[k] == d) ? 2'd0 : 2'd3;
  endtask

  // m = {wipe, init, write, read}
  task automatic model(input logic [3:0] m, input logic [DW-1:0] d, inout exp_t e);
    int j;
    e.st = 2'd0; e.lat = 0;
    if (m[3]) m_erase(e);
    else if (m[2]) begin
      j = -1;
      for (int i = NS - 1; i >= 0; i--) if (mdl[i] != '1) j = i;
      if (j >= 0) e.lat = j + 1;
      else begin e.lat = NS; m_erase(e); end
    end else if (m[1]) begin
      j = -1;
      for (int i = NS - 1; i >= 0; i--) if (mdl[i] == '1) j = i;
      if (j >= 0) begin e.lat = j + 1; m_prog(e, j, d); end
      else begin
        e.lat = NS; m_erase(e);
        if (e.st == 2'd0) m_prog(e, 0, d);
      end
    end else begin
      j = -1;
      for (int i = 0; i < NS; i++) if (mdl[i] != '1) j = i;
      if (j >= 0) begin e.lat = NS - j; cur_val = mdl[j]; end
      else begin e.lat = NS; cur_val = '1; end
    end
    e.val = cur_val;
  endtask

  task automatic issue(input logic [3:0] m, input logic [DW-1:0] d, input string tag, input bit poke);
    exp_t e;
    e.tag = tag;
    model(m, d, e);
    q.push_back(e);
    @(negedge clk);
    {wipe_req, init_req, wr_req, rd_req} = m;
    wr_data = d;
    @(negedge clk);
    {wipe_req, init_req, wr_req, rd_req} = 4'b0;
    if (poke) begin
      rd_req = 1'b1; wipe_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0; wipe_req = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare each finished operation against the scoreboard.
  initial begin
    int  cnt = 0;
    bit  prev = 0;
    forever begin
      @(negedge clk);
      if (rst) begin cnt = 0; prev = 0; end
      else if (busy) cnt++;
      else if (prev) begin
        if (q.size() == 0) begin
          chk("R2", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "status", status, e.st);
          chk(e.tag, "value", rd_value, e.val);
          chk(e.tag, "busy cycles", cnt, e.lat);
        end
        cnt = 0;
      end
      if (!rst) prev = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) mdl[i] = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "status", status, 0);
    chk("R1", "value", rd_value, 16'hFFFF);

    issue(4'b0001, '0, "R6", 0);          // blank read
    issue(4'b0100, '0, "R8", 0);          // init on blank page erases
    issue(4'b0010, 16'hA5A5, "R3", 0);    // slot 0
    issue(4'b0010, 16'h5A0F, "R3", 0);    // slot 1
    issue(4'b0001, '0, "R6", 0);
    issue(4'b0100, '0, "R8", 0);          // data present: untouched
    issue(4'b0001, '0, "R8", 0);
    issue(4'b0010, 16'hFFFF, "R3", 0);    // leaves slot 2 erased
    issue(4'b0001, '0, "R6", 0);
    for (int i = 0; i < NS - 2; i++) issue(4'b0010, 16'(16'h1000 + i), "R3", 0);
    issue(4'b0001, '0, "R6", 0);
    issue(4'b0010, 16'hBEEF, "R4", 0);    // full page wraps
    issue(4'b0001, '0, "R4", 0);
    issue(4'b0011, 16'hC0DE, "R2", 0);    // write beats read
    issue(4'b0001, '0, "R2", 0);
    issue(4'b1010, 16'h7777, "R2", 0);    // wipe beats write
    issue(4'b0010, 16'h1234, "R2", 1);    // requests during busy ignored
    issue(4'b0001, '0, "R2", 0);
    stuck = 16'h0001;
    issue(4'b0010, 16'h0003, "R5", 0);    // stuck bit -> verify error
    issue(4'b0001, '0, "R5", 0);
    issue(4'b1000, '0, "R7", 0);          // erase error
    issue(4'b0010, 16'h0002, "R7", 0);    // no blank slot, erase fails
    stuck = '0;
    issue(4'b1000, '0, "R7", 0);          // clean wipe
    issue(4'b0001, '0, "R6", 0);
    chk("R9", "status never 1", (status == 2'd1), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule